// File: doc/BRIEF.md
# Masked Restart Interrupt Controller

This block is the interrupt front end of a small 8-bit processor. It holds a global interrupt-enable flag, three restart request lines with a mask bit each, and a pending view of every line. While the global flag is set and at least one line is both pending and unmasked, the block raises a request and presents the restart vector of the winning line. When the processor accepts the request, the global flag drops. If the accepted line is the edge-triggered one, its latched pending bit is cleared in the same step.

Software reaches the block through one byte-wide write port and one byte-wide read port. The write byte updates the masks only when its update-enable bit is set. It can also discard a latched edge on its own. The read byte returns the pending bits, the global flag and the masks together. Lines 0 and 1 are level-sensitive and are registered once. Line 2 is edge-triggered: a rising edge is latched and held until it is serviced or discarded.

Top module: `rim_ctrl_top`

## Requirements
- R1: After reset the global flag is 0, all three masks are 1 (masked), nothing is pending, `rd_data` reads 8'h07 and `irq_req` is 0.
- R2: `cmd_ei` sets the global flag and `cmd_di` clears it, visible on `rd_data[3]` after the next clock edge. If both are high together, the flag ends up clear. While the flag is clear, `irq_req` stays 0.
- R3: A write (`wr_en`=1) with `wr_data[3]`=1 loads `wr_data[2:0]` into the masks of lines 2..0 at the next edge, where 1 means masked. With `wr_data[3]`=0 the masks keep their value.
- R4: `rd_data` reads {1'b0, pending[2:0], global flag, mask[2:0]}: bit 7 is always 0, bits 6:4 are pending of lines 2..0, bit 3 is the global flag, and bits 2:0 are the masks.
- R5: The pending bits of lines 0 and 1 equal the line input as sampled at the last clock edge. They are not latched.
- R6: A 0-to-1 change on line 2 sets its pending bit two clock edges after the input rises. The bit stays set after the input falls, and a line held high does not set it again.
- R7: `irq_req` is 1 exactly when the global flag is set and some line is both pending and unmasked.
- R8: The highest-numbered unmasked pending line wins. `vec_addr` is (5+n)*8 for line n: 8'h28, 8'h30 and 8'h38. The low three bits of `vec_addr` are always 0 while a request is shown.
- R9: `ack` while `irq_req` is 1 clears the global flag at the next edge. If line 2 was the winner, it also clears line 2's pending bit. `ack` while `irq_req` is 0 changes nothing.
- R10: A write with `wr_data[4]`=1 clears line 2's pending bit at the next edge.
- R11: When a new line-2 edge falls in the same cycle as a clear of line 2's pending bit (by acceptance or by write), the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 3 | Restart request lines; line 2 is edge-triggered |
| cmd_ei | input | 1 | Enable command, sets the global flag |
| cmd_di | input | 1 | Disable command, clears the global flag |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | bit 4 clear line-2 pending, bit 3 mask update enable, bits 2:0 masks |
| rd_data | output | 8 | Status byte: pending, global flag, masks |
| ack | input | 1 | Processor accepts the current request |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_addr | output | 8 | Restart vector of the winning line |

## Verification
Two events can meet in one cycle: a newly detected edge on line 2, and a clear of that line's pending bit. The clear comes either from acceptance of line 2 or from a write with the clear bit. The bench first latches an edge and then drops the line. It raises the line again so that the edge is seen exactly in the cycle where it asserts `ack` or writes the clear bit. The result is judged by the pending bit reading back as set while the global flag has dropped. Random runs of `ack`, writes and line activity produce the same meeting many more times, and each one is compared against the bench model.

// File: rtl/rim_pkg.sv
package rim_pkg;
    localparam int NLINE      = 3;
    localparam int EDGE_IDX   = NLINE - 1;
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 5;
    localparam int VEC_SHIFT  = 3;
    localparam int SEL_W      = $clog2(NLINE);

    localparam int WB_MASK_LO = 0;
    localparam int WB_SETEN   = 3;
    localparam int WB_CLRPEND = 4;
    localparam int RB_MASK_LO = 0;
    localparam int RB_IE      = 3;
    localparam int RB_PEND_LO = 4;

    typedef struct packed {
        logic             ie;
        logic [NLINE-1:0] mask;
        logic             edge_pend;
    } rim_state_t;

    localparam rim_state_t RIM_RESET = '{ie: 1'b0, mask: '1, edge_pend: 1'b0};
endpackage

// File: rtl/rim_line_sampler.sv
module rim_line_sampler #(
    parameter int N        = 3,
    parameter int EDGE_POS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    output logic [N-1:0] level_q,
    output logic         edge_pulse
);
    typedef struct packed {
        logic [N-1:0] samp;
        logic         prev;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.samp = line_in;
        s_d.prev = s_q.samp[EDGE_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_q    = s_q.samp;
    assign edge_pulse = s_q.samp[EDGE_POS] & ~s_q.prev;
endmodule

// File: rtl/rim_vec_select.sv
module rim_vec_select #(
    parameter int N     = 3,
    parameter int BASE  = 5,
    parameter int SHIFT = 3,
    parameter int VW    = 8,
    parameter int SW    = $clog2(N)
) (
    input  logic [N-1:0]  active,
    output logic          any,
    output logic [SW-1:0] sel,
    output logic [VW-1:0] vec
);
    logic [VW-1:0] vec_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        assign vec_tab[g] = VW'((BASE + g) << SHIFT);
    end

    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (active[i]) begin
                any = 1'b1;
                sel = SW'(i);
            end
        end
    end

    assign vec = any ? vec_tab[sel] : '0;
endmodule

// File: rtl/rim_ctrl_top.sv
module rim_ctrl_top
    import rim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] irq_in,
    input  logic             cmd_ei,
    input  logic             cmd_di,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec_addr
);
    rim_state_t st_d, st_q;

    logic [NLINE-1:0] level_q;
    logic             edge_pulse;
    logic [NLINE-1:0] pend;
    logic [NLINE-1:0] active;
    logic             any_act;
    logic [SEL_W-1:0] win_sel;
    logic             take;
    logic             clr_edge;

    rim_line_sampler #(.N(NLINE), .EDGE_POS(EDGE_IDX)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (irq_in),
        .level_q    (level_q),
        .edge_pulse (edge_pulse)
    );

    always_comb begin
        pend           = level_q;
        pend[EDGE_IDX] = st_q.edge_pend;
    end

    assign active = pend & ~st_q.mask;

    rim_vec_select #(
        .N(NLINE), .BASE(VEC_BASE), .SHIFT(VEC_SHIFT), .VW(VEC_W), .SW(SEL_W)
    ) u_sel (
        .active (active),
        .any    (any_act),
        .sel    (win_sel),
        .vec    (vec_addr)
    );

    assign irq_req  = st_q.ie & any_act;
    assign take     = ack & irq_req;
    assign clr_edge = (take && win_sel == SEL_W'(EDGE_IDX)) || (wr_en && wr_data[WB_CLRPEND]);

    always_comb begin
        st_d = st_q;
        if (cmd_ei) st_d.ie = 1'b1;
        if (cmd_di) st_d.ie = 1'b0;
        if (take)   st_d.ie = 1'b0;
        if (wr_en && wr_data[WB_SETEN])
            st_d.mask = wr_data[WB_MASK_LO +: NLINE];
        if (clr_edge)   st_d.edge_pend = 1'b0;
        if (edge_pulse) st_d.edge_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RIM_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data                          = '0;
        rd_data[RB_MASK_LO +: NLINE]     = st_q.mask;
        rd_data[RB_IE]                   = st_q.ie;
        rd_data[RB_PEND_LO +: NLINE]     = pend;
    end
endmodule

// File: rtl/rim_ctrl_chk.sv
module rim_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_di,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ack,
    input logic [7:0] rd_data,
    input logic       irq_req,
    input logic [7:0] vec_addr
);
    p_req_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> rd_data[3]);

    p_di_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di |=> !rd_data[3]);

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[3]) |=> rd_data[2:0] == $past(rd_data[2:0]));

    p_top_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7]);

    p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2:0] == 3'b111) |-> !irq_req);

    p_vec_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> vec_addr[2:0] == 3'b000);

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && rd_data[6] && !rd_data[2]) |-> vec_addr == 8'h38);

    p_ack_drops_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> !rd_data[3]);

    p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && !ack && !(wr_en && wr_data[4])) |=> rd_data[6]);
endmodule

bind rim_ctrl_top rim_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_di   (cmd_di),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ack      (ack),
    .rd_data  (rd_data),
    .irq_req  (irq_req),
    .vec_addr (vec_addr)
);

// File: tb/test_rim_ctrl_top.sv
module test_rim_ctrl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] irq_in = '0;
    logic       cmd_ei = 1'b0, cmd_di = 1'b0, wr_en = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, vec_addr;
    logic       irq_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // scoreboard model
    logic       m_ie, m_pend2, m_old;
    logic [2:0] m_mask, m_samp;

    always #5 clk = ~clk;

    rim_ctrl_top i_rim_ctrl_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
        .irq_req(irq_req), .vec_addr(vec_addr)
    );

    function automatic logic [2:0] f_act();
        return {m_pend2, m_samp[1:0]} & ~m_mask;
    endfunction

    function automatic logic f_req();
        return m_ie && (f_act() != 3'b000);
    endfunction

    function automatic logic [7:0] f_vec();
        logic [2:0] a = f_act();
        if (a[2]) return 8'h38;
        if (a[1]) return 8'h30;
        if (a[0]) return 8'h28;
        return 8'h00;
    endfunction

    function automatic logic [7:0] f_rd();
        return {1'b0, m_pend2, m_samp[1:0], m_ie, m_mask};
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ie = 1'b0; m_mask = 3'b111; m_samp = '0; m_old = 1'b0; m_pend2 = 1'b0;
    endtask

    task automatic model_edge();
        logic take, edge_seen, clr;
        take      = ack && f_req();
        edge_seen = m_samp[2] && !m_old;
        clr       = (take && f_act()[2]) || (wr_en && wr_data[4]);
        if (cmd_ei) m_ie = 1'b1;
        if (cmd_di) m_ie = 1'b0;
        if (take)   m_ie = 1'b0;
        if (wr_en && wr_data[3]) m_mask = wr_data[2:0];
        if (clr)       m_pend2 = 1'b0;
        if (edge_seen) m_pend2 = 1'b1;
        m_old  = m_samp[2];
        m_samp = irq_in;
    endtask

    // one clock: inputs already driven, advance, compare against model (R4, R7, R8)
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(rd_data, f_rd(), "R4 rd_data");
        chk({7'b0, irq_req}, {7'b0, f_req()}, "R7 irq_req");
        if (f_req()) chk(vec_addr, f_vec(), "R8 vec_addr");
    endtask

    task automatic drive(input logic [2:0] irq, input logic ei, input logic di,
                         input logic we, input logic [7:0] wd, input logic ak);
        irq_in = irq; cmd_ei = ei; cmd_di = di; wr_en = we; wr_data = wd; ack = ak;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rd_data, 8'h07, "R1 reset rd_data");
        chk({7'b0, irq_req}, 8'h00, "R1 reset irq_req");

        drive(3'b000, 0, 0, 1, 8'h08, 0); step(); chk(rd_data, 8'h00, "R3 mask load");
        drive(3'b000, 0, 0, 1, 8'h05, 0); step(); chk(rd_data, 8'h00, "R3 no update without enable bit");
        drive(3'b000, 0, 0, 1, 8'h0D, 0); step(); chk(rd_data, 8'h05, "R3 mask 101");
        drive(3'b000, 1, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h0D, "R2 enable");
        drive(3'b000, 1, 1, 0, 8'h00, 0); step(); chk(rd_data, 8'h05, "R2 both commands disable");
        drive(3'b001, 0, 0, 1, 8'h08, 0); step(); chk(rd_data, 8'h10, "R5 level pending");
        chk({7'b0, irq_req}, 8'h00, "R2 no request while flag clear");
        drive(3'b001, 1, 0, 0, 8'h00, 0); step(); chk(vec_addr, 8'h28, "R8 line0 vector");
        drive(3'b000, 0, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h08, "R5 level not latched");
        drive(3'b100, 0, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h08, "R6 not yet pending");
        drive(3'b100, 0, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h48, "R6 edge latched");
        drive(3'b101, 0, 0, 0, 8'h00, 0); step(); chk(vec_addr, 8'h38, "R8 highest line wins");
        drive(3'b001, 0, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h58, "R6 sticky after fall");
        drive(3'b001, 0, 0, 0, 8'h00, 1); step(); chk(rd_data, 8'h10, "R9 accept clears flag and edge");
        drive(3'b001, 0, 0, 0, 8'h00, 1); step(); chk(rd_data, 8'h10, "R9 ack without request ignored");
        drive(3'b000, 1, 0, 0, 8'h00, 0); step();
        drive(3'b100, 0, 0, 0, 8'h00, 0); step();
        drive(3'b100, 0, 0, 0, 8'h00, 0); step(); chk(rd_data, 8'h48, "R6 second edge");
        drive(3'b100, 0, 0, 1, 8'h10, 0); step(); chk(rd_data, 8'h08, "R10 write clears edge");
        drive(3'b000, 0, 0, 0, 8'h00, 0); step();
        drive(3'b100, 0, 0, 0, 8'h00, 0); step();
        drive(3'b100, 0, 0, 1, 8'h10, 0); step(); chk(rd_data, 8'h48, "R11 edge beats write clear");
        drive(3'b000, 0, 0, 0, 8'h00, 0); step();
        drive(3'b100, 0, 0, 0, 8'h00, 0); step(); chk({7'b0, irq_req}, 8'h01, "R11 request before collision");
        drive(3'b100, 0, 0, 0, 8'h00, 1); step(); chk(rd_data, 8'h40, "R11 edge beats accept clear");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            drive(r[2:0], r[3] & r[4], r[5] & r[6] & r[7], (r[11:8] == 4'h0), r[19:12], r[20]);
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule